// File: doc/BRIEF.md
# Oscillator Band Selection Sequencer

This block picks one of eight overlapping oscillator bands by a successive-approximation search. A search begins when reset is released and again each time the feedback divider setting is rewritten, which the surrounding logic signals with a one-cycle update pulse. The search runs on a slow selection tick. That tick comes from the reference-divider output clock, which is divided by 1, 2, 4 or 8 through a clock enable, so all state stays in the single input clock domain.

While the search runs, the block asserts a tune-switch output. This output disconnects the oscillator control voltage from the loop filter and ties it to an internal reference. The block offers a trial band code to an external frequency comparator. The comparator answers whether the oscillator is running faster than the target. Five selection ticks after the start, the block releases the switch, latches the chosen 3-bit code and pulses a done flag.

A separate combinational flag warns when the supplied reference-divider output frequency, after the prescale, would exceed the 1 MHz ceiling of the selection clock.

Top module: `vco_band_sel`

## Requirements
- R1: While rst_ni is low, tune_sw_o is 1, done_o is 0 and band_o is 3'b000.
- R2: After reset release, a search starts by itself, and tune_sw_o stays high for exactly 5*D clock cycles, where D is the prescale divide ratio.
- R3: A one-cycle pulse on upd_i while idle starts a search: tune_sw_o is high from the next cycle for exactly 5*D cycles.
- R4: presc_sel_i encodings 2'b00, 2'b01, 2'b10 and 2'b11 give D = 1, 2, 4 and 8.
- R5: probe_band_o is 3'b100 in the cycle after a start. Bits are then resolved from bit 2 down to bit 0, one per tick. A bit under trial is cleared when faster_i is 1 and kept when it is 0, and the next lower bit is then set for trial. With a monotonic comparator (faster_i = probe_band_o > target), the result equals the target.
- R6: done_o is high for exactly one cycle, in the first cycle in which tune_sw_o is low after a search.
- R7: band_o keeps the previous result throughout a search and changes only in the cycle where done_o is high.
- R8: An upd_i pulse during a search restarts it from the first step: tune_sw_o stays high, and the 5*D count starts again from that pulse.
- R9: rate_err_o is 1 exactly when ref_khz_i > 1000*D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference-divider output clock |
| rst_ni | input | 1 | Active-low asynchronous reset (power-up) |
| presc_sel_i | input | 2 | Prescale select, divide by 1/2/4/8 |
| ref_khz_i | input | 16 | Frequency of clk_i in kHz, used for the rate check |
| upd_i | input | 1 | Feedback divider setting was rewritten (one-cycle pulse) |
| faster_i | input | 1 | Comparator: oscillator at the trial band is faster than the target |
| tune_sw_o | output | 1 | Control voltage tied to the internal reference while high |
| probe_band_o | output | 3 | Trial band code offered to the comparator |
| band_o | output | 3 | Selected band code |
| done_o | output | 1 | One-cycle pulse when a search completes |
| rate_err_o | output | 1 | Prescaled selection clock above 1 MHz |

## Verification
The hardest case to reach from the ports is a restart that lands partway through a search. It must lie on a prescaled tick boundary as well as off one, and the new search must time out in full from the later pulse. The bench issues a second update after a varying number of cycles, against several prescale settings. It changes the comparator target between the two pulses, so a search that was not restarted would give a visibly wrong code. The comparator is modelled in the bench as a monotonic compare of the trial code against a target, and all 32 combinations of prescale and target are swept.

// File: rtl/vbs_pkg.sv
package vbs_pkg;
  localparam int BAND_W  = 3;
  localparam int N_STEPS = BAND_W + 2;  // init, one per bit, settle
  localparam int SEL_W   = 2;
  localparam int N_SEL   = 1 << SEL_W;
  localparam int CNT_W   = N_SEL - 1;   // holds up to divide-by-8 minus 1
  typedef logic [BAND_W-1:0] band_t;
endpackage

// File: rtl/vbs_prescale.sv
module vbs_prescale
  import vbs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             clr_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  always_comb begin
    last = '0;
    for (int i = 0; i < CNT_W; i++)
      if (i < int'(sel_i)) last[i] = 1'b1;
  end

  assign tick_o = (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || tick_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/vbs_rate_chk.sv
module vbs_rate_chk
  import vbs_pkg::*;
#(
  parameter int KHZ_W   = 16,
  parameter int MAX_KHZ = 1000
) (
  input  logic [KHZ_W-1:0] ref_khz_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             err_o
);
  localparam int TH_W = 32;
  logic [TH_W-1:0] thr [N_SEL];

  for (genvar g = 0; g < N_SEL; g++) begin : g_thr
    assign thr[g] = TH_W'(MAX_KHZ) << g;
  end

  // compare against scaled limit: exact, no division
  assign err_o = {{(TH_W-KHZ_W){1'b0}}, ref_khz_i} > thr[sel_i];
endmodule

// File: rtl/vbs_search.sv
module vbs_search
  import vbs_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  logic  tick_i,
  input  logic  faster_i,
  output logic  busy_o,
  output band_t trial_o,
  output band_t band_o,
  output logic  done_o
);
  localparam int    STEP_W  = $clog2(N_STEPS);
  localparam band_t MSB_ONE = band_t'(1) << (BAND_W - 1);

  logic [STEP_W-1:0] step_q;
  logic              busy_q, done_q;
  band_t             trial_q, trial_d, band_q;
  int                bidx;

  assign bidx = BAND_W - int'(step_q);

  // resolve bit bidx, raise bit bidx-1 for the next trial
  always_comb begin
    trial_d = trial_q;
    for (int i = 0; i < BAND_W; i++) begin
      if (i == bidx && faster_i) trial_d[i] = 1'b0;
      if (i + 1 == bidx)         trial_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b1;
      step_q  <= '0;
      trial_q <= MSB_ONE;
      band_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q  <= 1'b1;
        step_q  <= '0;
        trial_q <= MSB_ONE;
      end else if (busy_q && tick_i) begin
        step_q <= step_q + 1'b1;
        if (step_q == '0) begin
          trial_q <= MSB_ONE;
        end else if (int'(step_q) <= BAND_W) begin
          trial_q <= trial_d;
        end else begin
          band_q <= trial_q;
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o  = busy_q;
  assign trial_o = trial_q;
  assign band_o  = band_q;
  assign done_o  = done_q;
endmodule

// File: rtl/vco_band_sel.sv
module vco_band_sel
  import vbs_pkg::*;
#(
  parameter int KHZ_W   = 16,
  parameter int MAX_KHZ = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  presc_sel_i,
  input  logic [KHZ_W-1:0]  ref_khz_i,
  input  logic              upd_i,
  input  logic              faster_i,
  output logic              tune_sw_o,
  output logic [BAND_W-1:0] probe_band_o,
  output logic [BAND_W-1:0] band_o,
  output logic              done_o,
  output logic              rate_err_o
);
  logic tick;

  vbs_prescale u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (presc_sel_i),
    .clr_i  (upd_i),
    .tick_o (tick)
  );

  vbs_search u_srch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (upd_i),
    .tick_i   (tick),
    .faster_i (faster_i),
    .busy_o   (tune_sw_o),
    .trial_o  (probe_band_o),
    .band_o   (band_o),
    .done_o   (done_o)
  );

  vbs_rate_chk #(.KHZ_W(KHZ_W), .MAX_KHZ(MAX_KHZ)) u_rate (
    .ref_khz_i (ref_khz_i),
    .sel_i     (presc_sel_i),
    .err_o     (rate_err_o)
  );
endmodule

// File: rtl/vco_band_sel_chk.sv
module vco_band_sel_chk
  import vbs_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              upd_i,
  input logic              tune_sw_o,
  input logic              done_o,
  input logic [BAND_W-1:0] band_o,
  input logic [BAND_W-1:0] probe_band_o
);
  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r6_done_at_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tune_sw_o) |-> done_o);

  a_r6_no_done_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !tune_sw_o);

  a_r7_band_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(band_o));

  a_r8_restart_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> (tune_sw_o && !done_o));

  a_r5_first_trial: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> (probe_band_o == 3'b100));
endmodule

bind vco_band_sel vco_band_sel_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .upd_i        (upd_i),
  .tune_sw_o    (tune_sw_o),
  .done_o       (done_o),
  .band_o       (band_o),
  .probe_band_o (probe_band_o)
);

// File: tb/sim_vco_band_sel.sv
`timescale 1ns/1ps
module sim_vco_band_sel;
  localparam int CLK_P = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] presc_sel_i = 2'd0;
  logic [15:0] ref_khz_i = 16'd500;
  logic       upd_i = 1'b0;
  logic       faster_i;
  logic       tune_sw_o, done_o, rate_err_o;
  logic [2:0] probe_band_o, band_o;
  int         target = 0;
  int         n_chk = 0, n_bad = 0, cyc = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  // monotonic comparator model
  assign faster_i = (int'(probe_band_o) > target);

  vco_band_sel u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .presc_sel_i(presc_sel_i),
    .ref_khz_i(ref_khz_i), .upd_i(upd_i), .faster_i(faster_i),
    .tune_sw_o(tune_sw_o), .probe_band_o(probe_band_o), .band_o(band_o),
    .done_o(done_o), .rate_err_o(rate_err_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  // count cycles with tune_sw high, starting at the current negedge
  task automatic count_busy(output int n);
    n = 0;
    while (tune_sw_o && n < 1000) begin
      n++;
      @(negedge clk_i);
    end
  endtask

  task automatic pulse_upd();
    upd_i = 1'b1;
    @(negedge clk_i);
    upd_i = 1'b0;
  endtask

  initial begin
    int n;
    int prev;
    // R1: reset state
    presc_sel_i = 2'd2;
    target = 5;
    repeat (3) @(negedge clk_i);
    check(tune_sw_o == 1'b1, "R1 tune_sw", int'(tune_sw_o), 1);
    check(done_o == 1'b0, "R1 done", int'(done_o), 0);
    check(band_o == 3'd0, "R1 band", int'(band_o), 0);

    // R2: power-up search, D=4
    rst_ni = 1'b1;
    count_busy(n);
    check(n == 20, "R2 power-up length", n, 20);
    check(done_o == 1'b1, "R6 done after power-up", int'(done_o), 1);
    check(int'(band_o) == 5, "R5 power-up band", int'(band_o), 5);
    @(negedge clk_i);
    check(done_o == 1'b0, "R6 done one cycle", int'(done_o), 0);

    // R3/R4/R5/R6/R7: sweep prescale x target
    for (int s = 0; s < 4; s++) begin
      for (int t = 0; t < 8; t++) begin
        presc_sel_i = 2'(s);
        prev = int'(band_o);
        target = t;
        pulse_upd();
        check(probe_band_o == 3'b100, "R5 first trial", int'(probe_band_o), 4);
        check(int'(band_o) == prev, "R7 band held", int'(band_o), prev);
        count_busy(n);
        check(n == 5 * (1 << s), "R3 R4 search length", n, 5 * (1 << s));
        check(done_o == 1'b1, "R6 done", int'(done_o), 1);
        check(int'(band_o) == t, "R5 result", int'(band_o), t);
        @(negedge clk_i);
        check(done_o == 1'b0, "R6 done drops", int'(done_o), 0);
        check(int'(band_o) == t, "R7 band kept idle", int'(band_o), t);
      end
    end

    // R8: restart mid-search with a new target
    for (int s = 0; s < 4; s++) begin
      for (int k = 1; k < 5 * (1 << s); k += 1 + s) begin
        presc_sel_i = 2'(s);
        target = 1;
        pulse_upd();
        repeat (k - 1) @(negedge clk_i);
        target = 6;
        pulse_upd();
        count_busy(n);
        check(n == 5 * (1 << s), "R8 restart length", n, 5 * (1 << s));
        check(int'(band_o) == 6, "R8 restart result", int'(band_o), 6);
        @(negedge clk_i);
      end
    end

    // R9: rate flag around each threshold
    for (int s = 0; s < 4; s++) begin
      for (int d = -1; d <= 1; d++) begin
        int f;
        f = 1000 * (1 << s) + d;
        presc_sel_i = 2'(s);
        ref_khz_i = 16'(f);
        #1;
        check(rate_err_o == (f > 1000 * (1 << s)), "R9 rate flag",
              int'(rate_err_o), int'(f > 1000 * (1 << s)));
      end
    end
    ref_khz_i = 16'd65535;
    presc_sel_i = 2'd3;
    #1;
    check(rate_err_o == 1'b1, "R9 rate flag max", int'(rate_err_o), 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule